// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides, every clock cycle, whether a small processor core must be interrupted and to which address it must jump. Each interrupt source supplies a level flag. Software controls each source through an enable bit and a priority bit, and controls the whole block through two global enables and a mode bit. The mode bit selects between one flat level and two levels. In the two-level mode, high-priority requests jump to 0x0008 and low-priority requests jump to 0x0018. In the flat mode every request jumps to 0x0008. In the flat mode the low-level global enable instead gates a fixed group of peripheral sources.

The request and vector outputs are registered. They are computed from the flags and from the enable state that will be in force after the current clock edge. A register write therefore takes effect for gating in the same cycle as the flag it races against. When the core acknowledges a request, the block clears the global enable that belongs to the accepted level. A return-from-interrupt pulse sets that enable again. Returns unwind in last-in, first-out order, so a low-level routine that was pre-empted by a high-level one gets its own enable back on its own return.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both global enables, the mode bit, all source enables, all priority bits and the request are 0.
- R2: With the mode bit at 0, an enabled non-peripheral source with its flag high raises the request with vector 0x0008 at the next clock edge, provided the high global enable is 1. Clearing the high global enable drops the request at the edge of that write.
- R3: With the mode bit at 0, a peripheral source (default mask 0xF0, sources 4 to 7) also needs the low global enable set. Sources 0 to 3 do not need it.
- R4: With the mode bit at 1, an enabled source whose priority bit is 1 requests vector 0x0008 whenever the high global enable is 1, whatever the low global enable is.
- R5: With the mode bit at 1, a source whose priority bit is 0 requests vector 0x0018 only when both global enables are 1. The high global enable at 0 blocks every request at both levels.
- R6: When high and low sources are both eligible, the vector is 0x0008.
- R7: Acknowledging a 0x0008 request clears the high global enable. Acknowledging a 0x0018 request clears the low global enable. The request is then recomputed with the cleared enable at the same edge.
- R8: While a low-level request is in service (low enable cleared by its acknowledge), a newly eligible high source raises a 0x0008 request.
- R9: A return pulse sets the enable cleared by the most recent still-open acknowledge: the high enable first, then the low enable.
- R10: Writing a source enable to 0 in the same cycle that its flag rises starts no request.
- R11: The global enables change only through control writes, acknowledges and returns. Flag activity and the disable order (low then high) or re-enable order (high then low) never set the high enable or clear the low enable on their own.
- R12: A write with register select 3 changes no state. Select 0 is control (bit 0 high enable, bit 1 low enable, bit 2 mode). Select 1 is the source enables. Select 2 is the priority bits (1 = high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcFlag | input | NUM_SRC | Level interrupt flags from the sources |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 control, 1 enables, 2 priorities, 3 none |
| wrData | input | NUM_SRC | Write data |
| irqAck | input | 1 | Core accepts the current request |
| irqRet | input | 1 | Core returns from an interrupt routine |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | VEC_W | Jump address for the request |
| gieHigh | output | 1 | High global enable state |
| gieLow | output | 1 | Low global enable / peripheral group enable state |
| prioMode | output | 1 | Two-level mode bit |
| srcEnable | output | NUM_SRC | Source enable bits |
| srcPrio | output | NUM_SRC | Source priority bits |

## Verification
The bench targets three kinds of fault. The first is the race between an enable being cleared and a flag rising in the same cycle; a design that gates with the old register value would emit a one-cycle request. The second is a low-level source in two-level mode with the high enable off; a design that gates low requests only by the low enable would let it through. The third is the nested service sequence of low accepted, then high pre-empting, then two returns; a design with a single saved enable would restore the wrong bit and leave the low level locked or re-enable high too early. Writes to the unused select and disable/re-enable ordering are observed on the enable outputs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_PRIO   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_t;

  localparam int CTL_HIGH_BIT = 0;
  localparam int CTL_LOW_BIT  = 1;
  localparam int CTL_MODE_BIT = 2;

  typedef struct packed {
    logic setHigh;
    logic setLow;
    logic clrHigh;
    logic clrLow;
  } gieStrobe_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  gieStrobe_t         strobe,
  output logic               gieHighQ,
  output logic               gieLowQ,
  output logic               modeQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] prioQ,
  output logic               gieHighN,
  output logic               gieLowN,
  output logic               modeN,
  output logic [NUM_SRC-1:0] enN,
  output logic [NUM_SRC-1:0] prioN
);
  logic wrCtl, wrEnable, wrPrio;

  assign wrCtl    = wrEn && (regSel_t'(wrSel) == SEL_CTRL);
  assign wrEnable = wrEn && (regSel_t'(wrSel) == SEL_ENABLE);
  assign wrPrio   = wrEn && (regSel_t'(wrSel) == SEL_PRIO);

  always_comb begin
    gieHighN = gieHighQ;
    gieLowN  = gieLowQ;
    modeN    = modeQ;
    if (wrCtl) begin
      gieHighN = wrData[CTL_HIGH_BIT];
      gieLowN  = wrData[CTL_LOW_BIT];
      modeN    = wrData[CTL_MODE_BIT];
    end
    if (strobe.setHigh) gieHighN = 1'b1;
    if (strobe.setLow)  gieLowN  = 1'b1;
    if (strobe.clrHigh) gieHighN = 1'b0;
    if (strobe.clrLow)  gieLowN  = 1'b0;
    enN   = wrEnable ? wrData : enQ;
    prioN = wrPrio   ? wrData : prioQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieHighQ <= 1'b0;
      gieLowQ  <= 1'b0;
      modeQ    <= 1'b0;
      enQ      <= '0;
      prioQ    <= '0;
    end else begin
      gieHighQ <= gieHighN;
      gieLowQ  <= gieLowN;
      modeQ    <= modeN;
      enQ      <= enN;
      prioQ    <= prioN;
    end
  end

  // R11: the high enable only rises through a control write or a return strobe
  p_high_rise_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gieHighQ) |-> $past(strobe.setHigh || (wrCtl && wrData[CTL_HIGH_BIT])));
  // R11: the low enable only falls through a control write or a low acknowledge
  p_low_fall_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gieLowQ) |-> $past(strobe.clrLow || wrCtl));
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int               NUM_SRC     = 8,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = 8'hF0
) (
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] prio,
  input  logic               gieHigh,
  input  logic               gieLow,
  input  logic               mode,
  output logic               reqNext,
  output logic               lowNext
);
  logic [NUM_SRC-1:0] highElig, lowElig;
  logic               highAny, lowAny;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic live;
    assign live = flag[i] && en[i];
    if (PERIPH_MASK[i]) begin : g_periph
      assign highElig[i] = live && (mode ? prio[i] : gieLow);
    end else begin : g_core
      assign highElig[i] = live && (mode ? prio[i] : 1'b1);
    end
    assign lowElig[i] = live && mode && !prio[i];
  end

  assign highAny = gieHigh && (|highElig);
  assign lowAny  = gieHigh && gieLow && (|lowElig);
  assign reqNext = highAny || lowAny;
  assign lowNext = !highAny;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_HIGH = 16'h0008,
  parameter logic [VEC_W-1:0] VEC_LOW  = 16'h0018
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqAck,
  input  logic             irqRet,
  input  logic             reqNext,
  input  logic             lowNext,
  output gieStrobe_t       strobe,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVec
);
  logic inHigh, inLow, vecIsLow, accept;

  assign accept = irqAck && irqReq;

  always_comb begin
    strobe         = '0;
    strobe.clrHigh = accept && !vecIsLow;
    strobe.clrLow  = accept && vecIsLow;
    strobe.setHigh = irqRet && inHigh;
    strobe.setLow  = irqRet && !inHigh && inLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      vecIsLow <= 1'b0;
      inHigh   <= 1'b0;
      inLow    <= 1'b0;
    end else begin
      irqReq   <= reqNext;
      vecIsLow <= reqNext && lowNext;
      if (strobe.clrHigh)      inHigh <= 1'b1;
      else if (strobe.setHigh) inHigh <= 1'b0;
      if (strobe.clrLow)       inLow  <= 1'b1;
      else if (strobe.setLow)  inLow  <= 1'b0;
    end
  end

  assign irqVec = irqReq ? (vecIsLow ? VEC_LOW : VEC_HIGH) : '0;

  // R9: a return never sets both enables at once
  p_ret_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqRet |-> $countones({strobe.setHigh, strobe.setLow}) <= 1);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                 NUM_SRC     = 8,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = 8'hF0,
  parameter int                 VEC_W       = 16,
  parameter logic [VEC_W-1:0]   VEC_HIGH    = 16'h0008,
  parameter logic [VEC_W-1:0]   VEC_LOW     = 16'h0018
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               irqAck,
  input  logic               irqRet,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic               gieHigh,
  output logic               gieLow,
  output logic               prioMode,
  output logic [NUM_SRC-1:0] srcEnable,
  output logic [NUM_SRC-1:0] srcPrio
);
  gieStrobe_t         strobe;
  logic               gieHighN, gieLowN, modeN, reqNext, lowNext;
  logic [NUM_SRC-1:0] enN, prioN;
  logic               wrCtl;

  assign wrCtl = wrEn && (wrSel == 2'd0);

  irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe),
    .gieHighQ(gieHigh), .gieLowQ(gieLow), .modeQ(prioMode),
    .enQ(srcEnable), .prioQ(srcPrio),
    .gieHighN(gieHighN), .gieLowN(gieLowN), .modeN(modeN),
    .enN(enN), .prioN(prioN)
  );

  irq_select #(.NUM_SRC(NUM_SRC), .PERIPH_MASK(PERIPH_MASK)) u_sel (
    .flag(srcFlag), .en(enN), .prio(prioN),
    .gieHigh(gieHighN), .gieLow(gieLowN), .mode(modeN),
    .reqNext(reqNext), .lowNext(lowNext)
  );

  irq_ctrl #(.VEC_W(VEC_W), .VEC_HIGH(VEC_HIGH), .VEC_LOW(VEC_LOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .irqAck(irqAck), .irqRet(irqRet),
    .reqNext(reqNext), .lowNext(lowNext),
    .strobe(strobe), .irqReq(irqReq), .irqVec(irqVec)
  );

  // R5: no request of either level leaves while the high enable is off
  p_req_needs_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> gieHigh);
  // R5: a low vector needs two-level mode and the low enable
  p_low_vec_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqVec == VEC_LOW) |-> (gieLow && prioMode));
  // R7: accepting a high vector clears the high enable
  p_ack_high_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && irqVec == VEC_HIGH && !wrCtl) |=> !gieHigh);
  // R7: accepting a low vector clears only the low enable
  p_ack_low_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && irqVec == VEC_LOW && !wrCtl && !irqRet) |=> (!gieLow && $stable(gieHigh)));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  srcFlag = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [7:0]  wrData = '0;
  logic        irqAck = 1'b0;
  logic        irqRet = 1'b0;
  logic        irqReq;
  logic [15:0] irqVec;
  logic        gieHigh, gieLow, prioMode;
  logic [7:0]  srcEnable, srcPrio;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .irqAck(irqAck), .irqRet(irqRet), .irqReq(irqReq),
    .irqVec(irqVec), .gieHigh(gieHigh), .gieLow(gieLow), .prioMode(prioMode),
    .srcEnable(srcEnable), .srcPrio(srcPrio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs are set after a falling edge; one rising edge; outputs read at next falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic ack();
    irqAck = 1'b1; tick(); irqAck = 1'b0;
  endtask

  task automatic ret();
    irqRet = 1'b1; tick(); irqRet = 1'b0;
  endtask

  task automatic clean();
    srcFlag = '0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_reset_r1();
    chk("R1 req", irqReq, 0);
    chk("R1 enables", {gieHigh, gieLow, prioMode}, 0);
    chk("R1 src regs", {srcEnable, srcPrio}, 0);
  endtask

  task automatic t_flat_r2();
    clean();
    wr(2'd1, 8'h01); wr(2'd0, 8'h01);
    srcFlag = 8'h01; tick();
    chk("R2 flat req", {irqReq, irqVec}, {1'b1, 16'h0008});
    wr(2'd0, 8'h00);
    chk("R2 high enable off", irqReq, 0);
  endtask

  task automatic t_periph_r3();
    clean();
    wr(2'd1, 8'h10); wr(2'd0, 8'h01);
    srcFlag = 8'h10; tick();
    chk("R3 peripheral gated", irqReq, 0);
    wr(2'd0, 8'h03);
    chk("R3 peripheral passes", {irqReq, irqVec}, {1'b1, 16'h0008});
  endtask

  task automatic t_two_level_r4_r5();
    clean();
    wr(2'd2, 8'h01); wr(2'd1, 8'h03); wr(2'd0, 8'h05);
    srcFlag = 8'h02; tick();
    chk("R5 low needs low enable", irqReq, 0);
    wr(2'd0, 8'h07);
    chk("R5 low vector", {irqReq, irqVec}, {1'b1, 16'h0018});
    wr(2'd0, 8'h06);
    chk("R5 high enable off blocks low", irqReq, 0);
    srcFlag = 8'h01; wr(2'd0, 8'h05);
    chk("R4 high without low enable", {irqReq, irqVec}, {1'b1, 16'h0008});
  endtask

  task automatic t_preempt_r6();
    clean();
    wr(2'd2, 8'h01); wr(2'd1, 8'h03); wr(2'd0, 8'h07);
    srcFlag = 8'h03; tick();
    chk("R6 high wins", {irqReq, irqVec}, {1'b1, 16'h0008});
  endtask

  task automatic t_nesting_r7_r8_r9();
    clean();
    wr(2'd2, 8'h01); wr(2'd1, 8'h03); wr(2'd0, 8'h07);
    srcFlag = 8'h02; tick();
    chk("R7 low pending", {irqReq, irqVec}, {1'b1, 16'h0018});
    ack();
    chk("R7 low ack enables", {irqReq, gieHigh, gieLow}, 3'b010);
    srcFlag = 8'h03; tick();
    chk("R8 high pre-empts low service", {irqReq, irqVec}, {1'b1, 16'h0008});
    ack();
    chk("R7 high ack enables", {irqReq, gieHigh, gieLow}, 3'b000);
    srcFlag = 8'h02;
    ret();
    chk("R9 first return sets high", {irqReq, gieHigh, gieLow}, 3'b010);
    ret();
    chk("R9 second return sets low", {gieHigh, gieLow}, 2'b11);
    chk("R9 low request again", {irqReq, irqVec}, {1'b1, 16'h0018});
  endtask

  task automatic t_race_r10();
    clean();
    wr(2'd1, 8'h01); wr(2'd0, 8'h01);
    srcFlag = 8'h01; wr(2'd1, 8'h00);
    chk("R10 no request", irqReq, 0);
    chk("R10 enable cleared", srcEnable, 8'h00);
  endtask

  task automatic t_order_r11();
    clean();
    wr(2'd0, 8'h07);
    for (int i = 0; i < 6; i++) begin
      srcFlag = 8'(i * 37); tick();
    end
    chk("R11 flags leave enables", {gieHigh, gieLow}, 2'b11);
    srcFlag = 8'hFF;
    wr(2'd0, 8'h05);
    chk("R11 low off first", {gieHigh, gieLow}, 2'b10);
    wr(2'd0, 8'h04);
    chk("R11 then high off", {gieHigh, gieLow}, 2'b00);
    wr(2'd0, 8'h05);
    chk("R11 high on first", {gieHigh, gieLow}, 2'b10);
    wr(2'd0, 8'h07);
    chk("R11 then low on", {gieHigh, gieLow}, 2'b11);
  endtask

  task automatic t_ignored_r12();
    clean();
    wr(2'd0, 8'h05); wr(2'd1, 8'h5A); wr(2'd2, 8'h3C);
    wr(2'd3, 8'hFF);
    chk("R12 control kept", {gieHigh, gieLow, prioMode}, 3'b101);
    chk("R12 masks kept", {srcEnable, srcPrio}, {8'h5A, 8'h3C});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_flat_r2();
    t_periph_r3();
    t_two_level_r4_r5();
    t_preempt_r6();
    t_nesting_r7_r8_r9();
    t_race_r10();
    t_order_r11();
    t_ignored_r12();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule